// File: doc/BRIEF.md
# Buck Regulator Supervisory Sequencer

This block is the digital supervisor of a synchronous step-down regulator. It takes flags that are already digital: a shutdown request, supply-in-window, internal power-on-reset done, output over-voltage, output under-voltage, peak current limit, short circuit and over-temperature. It also takes a 2-bit soft-start select. From these it drives the converter enable, a soft-start ramp indication with a per-tick ramp step strobe, the output discharge enable and an active-low power-good.

Every flag passes through a two-flop synchronizer. All long times are counted in ticks of a shared prescaler, so a test build can shrink them. Each fault class is handled in its own way:
- Voltage excursions only release power-good.
- Current limit is tolerated for a window.
- A short circuit turns the converter off at once.
- Over-temperature holds the converter off until the flag clears and only then starts the retry timer.

Every restart passes through soft start.

Top module: `buck_supervisor`

## Requirements
- R1: While the synchronized shutdown request (`sd_n` low) is present, the converter is off, the discharge enable is high and power-good is high, within 3 clock edges of the request. The discharge enable is never high outside this state.
- R2: With `sd_n` high and `vin_ok` low, the block is in power-off: converter off, discharge off and power-good high.
- R3: After shutdown is released, the converter stays off until `por_done` is high. It then starts soft start, with `conv_en` and `ramp_active` both high.
- R4: Soft start lasts SS_UNIT_TICKS × K ticks, with K = 8, 4, 2, 1 for `ss_sel` = 0, 1, 2, 3. The code is sampled as soft start begins. `ramp_step` pulses once per tick, and only while `ramp_active` is high.
- R5: `pg_n` goes low only after PG_DELAY_TICKS ticks of running without a fault. During that window, the delay count is held at zero while a filtered voltage flag or the current limit is active. `pg_n` low implies that the converter is running and past soft start.
- R6: An over-voltage or under-voltage flag shorter than FILT_CYCLES clocks is ignored. A longer flag raises `pg_n` while `conv_en` stays high. When the flag clears, `pg_n` returns low with no new delay.
- R7: A current limit shorter than OC_WIN_TICKS ticks leaves the converter on. A longer one turns it off with `pg_n` high, waits RETRY_TICKS ticks, then restarts through soft start.
- R8: A short-circuit flag turns the converter off within 3 clock edges, and soft start restarts after RETRY_TICKS ticks.
- R9: An over-temperature flag turns the converter off within 3 clock edges. The converter stays off while the flag is high. The RETRY_TICKS timeout starts only after the flag clears.
- R10: Priority is shutdown, then supply, then thermal, then short, then current limit, then voltage flags. A shutdown request aborts a pending retry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sd_n | input | 1 | Run request, low requests shutdown |
| vin_ok | input | 1 | Input supply within operating window |
| por_done | input | 1 | Internal power-on reset released |
| ov_flag | input | 1 | Output above over-voltage threshold |
| uv_flag | input | 1 | Output below under-voltage threshold |
| ilim_flag | input | 1 | Peak current limit reached |
| short_flag | input | 1 | Short-circuit current reached |
| ot_flag | input | 1 | Over-temperature (comparator with hysteresis) |
| ss_sel | input | 2 | Soft-start length select |
| conv_en | output | 1 | Converter switching enable |
| ramp_active | output | 1 | Soft start in progress |
| ramp_step | output | 1 | One-cycle reference ramp step strobe |
| dischg_en | output | 1 | Output discharge path enable |
| pg_n | output | 1 | Power-good, active low |

## Verification
The hardest case to reach is the restart of the power-good delay. A voltage flag must outlast the filter yet begin and end inside the delay window that follows soft start. The bench measures the end of the ramp at the ports, raises under-voltage a fixed number of cycles later for longer than the filter, and then times how long `pg_n` stays high. The result must exceed the plain delay by the length of the excursion. The abort of a pending retry is reached the same way: a short circuit is followed by a shutdown request partway into the timeout.

// File: rtl/bsup_pkg.sv
package bsup_pkg;

    typedef enum logic [2:0] {
        ST_OFF      = 3'd0,
        ST_SHDN     = 3'd1,
        ST_WAIT_POR = 3'd2,
        ST_SOFT     = 3'd3,
        ST_RUN      = 3'd4,
        ST_RETRY    = 3'd5,
        ST_HOT      = 3'd6
    } bsup_state_e;

    localparam int NUM_FLAGS = 8;
    localparam int F_SD    = 7;
    localparam int F_VIN   = 6;
    localparam int F_POR   = 5;
    localparam int F_OV    = 4;
    localparam int F_UV    = 3;
    localparam int F_ILIM  = 2;
    localparam int F_SHORT = 1;
    localparam int F_OT    = 0;

endpackage

// File: rtl/bsup_sync.sv
module bsup_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    genvar g;
    generate
        for (g = 0; g < W; g++) begin : g_bit
            logic s1_q, s2_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    s1_q <= 1'b0;
                    s2_q <= 1'b0;
                end else begin
                    s1_q <= din[g];
                    s2_q <= s1_q;
                end
            end
            assign dout[g] = s2_q;
        end
    endgenerate
endmodule

// File: rtl/bsup_tick.sv
module bsup_tick #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (clr || cnt_q == LAST) cnt_d = '0;
        else                      cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign tick = (cnt_q == LAST);
endmodule

// File: rtl/bsup_persist.sv
module bsup_persist #(
    parameter int LEN = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic held
);
    localparam int CW = $clog2(LEN + 1);
    localparam logic [CW-1:0] TOP = CW'(LEN);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (!raw)             cnt_d = '0;
        else if (cnt_q < TOP) cnt_d = cnt_q + 1'b1;
        else                  cnt_d = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign held = raw && (cnt_q == TOP);
endmodule

// File: rtl/buck_supervisor.sv
module buck_supervisor
    import bsup_pkg::*;
#(
    parameter int TICK_DIV       = 400,
    parameter int SS_UNIT_TICKS  = 4,
    parameter int PG_DELAY_TICKS = 100,
    parameter int OC_WIN_TICKS   = 100,
    parameter int RETRY_TICKS    = 1000,
    parameter int FILT_CYCLES    = 80
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sd_n,
    input  logic       vin_ok,
    input  logic       por_done,
    input  logic       ov_flag,
    input  logic       uv_flag,
    input  logic       ilim_flag,
    input  logic       short_flag,
    input  logic       ot_flag,
    input  logic [1:0] ss_sel,
    output logic       conv_en,
    output logic       ramp_active,
    output logic       ramp_step,
    output logic       dischg_en,
    output logic       pg_n
);
    localparam int SS8   = SS_UNIT_TICKS * 8;
    localparam int MAX_A = (SS8 > RETRY_TICKS) ? SS8 : RETRY_TICKS;
    localparam int MAX_B = (OC_WIN_TICKS > PG_DELAY_TICKS) ? OC_WIN_TICKS : PG_DELAY_TICKS;
    localparam int MAXV  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int TW    = $clog2(MAXV + 1);

    localparam int SS4 = SS_UNIT_TICKS * 4;
    localparam int SS2 = SS_UNIT_TICKS * 2;
    localparam int SS1 = SS_UNIT_TICKS;

    localparam logic [TW:0] SS_L8   = SS8[TW:0];
    localparam logic [TW:0] SS_L4   = SS4[TW:0];
    localparam logic [TW:0] SS_L2   = SS2[TW:0];
    localparam logic [TW:0] SS_L1   = SS1[TW:0];
    localparam logic [TW:0] RETRY_L = RETRY_TICKS[TW:0];
    localparam logic [TW:0] OC_L    = OC_WIN_TICKS[TW:0];
    localparam logic [TW:0] PG_L    = PG_DELAY_TICKS[TW:0];

    typedef struct packed {
        bsup_state_e   state;
        logic [TW-1:0] tmr;
        logic [TW-1:0] oc_cnt;
        logic [TW-1:0] pg_cnt;
        logic          pg_done;
        logic [1:0]    ss_code;
    } regs_t;

    regs_t r_d, r_q;

    // synchronized flags
    logic [NUM_FLAGS-1:0] raw_flags, syn;
    assign raw_flags[F_SD]    = sd_n;
    assign raw_flags[F_VIN]   = vin_ok;
    assign raw_flags[F_POR]   = por_done;
    assign raw_flags[F_OV]    = ov_flag;
    assign raw_flags[F_UV]    = uv_flag;
    assign raw_flags[F_ILIM]  = ilim_flag;
    assign raw_flags[F_SHORT] = short_flag;
    assign raw_flags[F_OT]    = ot_flag;

    bsup_sync #(.W(NUM_FLAGS)) sync_i (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (raw_flags),
        .dout (syn)
    );

    // persistence filters on the two voltage flags
    logic [1:0] vraw, vheld;
    assign vraw = {syn[F_OV], syn[F_UV]};

    genvar gv;
    generate
        for (gv = 0; gv < 2; gv++) begin : g_vfilt
            bsup_persist #(.LEN(FILT_CYCLES)) filt_i (
                .clk  (clk),
                .rst_n(rst_n),
                .raw  (vraw[gv]),
                .held (vheld[gv])
            );
        end
    endgenerate

    logic v_fault;
    assign v_fault = |vheld;

    // tick prescaler, restarted on every state change
    logic tick, tick_clr;

    bsup_tick #(.DIV(TICK_DIV)) tick_i (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (tick_clr),
        .tick (tick)
    );

    logic          powered;
    logic          oc_expire;
    logic [TW:0]   tmr_inc, oc_inc, pg_inc, ss_len;
    bsup_state_e   nxt;

    always_comb begin
        powered = (r_q.state == ST_SOFT) || (r_q.state == ST_RUN);
        tmr_inc = {1'b0, r_q.tmr} + 1'b1;
        oc_inc  = {1'b0, r_q.oc_cnt} + 1'b1;
        pg_inc  = {1'b0, r_q.pg_cnt} + 1'b1;

        case (r_q.ss_code)
            2'd0:    ss_len = SS_L8;
            2'd1:    ss_len = SS_L4;
            2'd2:    ss_len = SS_L2;
            default: ss_len = SS_L1;
        endcase

        oc_expire = powered && syn[F_ILIM] && tick && (oc_inc >= OC_L);

        r_d = r_q;
        nxt = r_q.state;

        case (r_q.state)
            ST_OFF:      nxt = ST_WAIT_POR;
            ST_SHDN:     nxt = ST_WAIT_POR;
            ST_WAIT_POR: if (syn[F_POR]) nxt = ST_SOFT;
            ST_SOFT: begin
                if (syn[F_OT])                        nxt = ST_HOT;
                else if (syn[F_SHORT])                nxt = ST_RETRY;
                else if (oc_expire)                   nxt = ST_RETRY;
                else if (tick && (tmr_inc >= ss_len)) nxt = ST_RUN;
            end
            ST_RUN: begin
                if (syn[F_OT])         nxt = ST_HOT;
                else if (syn[F_SHORT]) nxt = ST_RETRY;
                else if (oc_expire)    nxt = ST_RETRY;
            end
            ST_RETRY: begin
                if (syn[F_OT])                         nxt = ST_HOT;
                else if (tick && (tmr_inc >= RETRY_L)) nxt = ST_WAIT_POR;
            end
            ST_HOT:      if (!syn[F_OT]) nxt = ST_RETRY;
            default:     nxt = ST_OFF;
        endcase

        // top-priority overrides
        if (!syn[F_SD])       nxt = ST_SHDN;
        else if (!syn[F_VIN]) nxt = ST_OFF;

        r_d.state = nxt;
        tick_clr  = (nxt != r_q.state);

        // state timer
        if (nxt != r_q.state) r_d.tmr = '0;
        else if (tick)        r_d.tmr = tmr_inc[TW-1:0];

        // soft-start code sampled as the ramp begins
        if (r_q.state == ST_WAIT_POR && nxt == ST_SOFT) r_d.ss_code = ss_sel;

        // current-limit window counter
        if (nxt != r_q.state || !powered || !syn[F_ILIM]) r_d.oc_cnt = '0;
        else if (tick)                                    r_d.oc_cnt = oc_inc[TW-1:0];

        // power-good delay
        if (r_q.state != ST_RUN || nxt != ST_RUN) begin
            r_d.pg_cnt  = '0;
            r_d.pg_done = 1'b0;
        end else if (!r_q.pg_done) begin
            if (v_fault || syn[F_ILIM]) begin
                r_d.pg_cnt = '0;
            end else if (tick) begin
                if (pg_inc >= PG_L) r_d.pg_done = 1'b1;
                else                r_d.pg_cnt  = pg_inc[TW-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state   <= ST_OFF;
            r_q.tmr     <= '0;
            r_q.oc_cnt  <= '0;
            r_q.pg_cnt  <= '0;
            r_q.pg_done <= 1'b0;
            r_q.ss_code <= 2'd0;
        end else begin
            r_q <= r_d;
        end
    end

    assign conv_en     = powered;
    assign ramp_active = (r_q.state == ST_SOFT);
    assign ramp_step   = (r_q.state == ST_SOFT) && tick;
    assign dischg_en   = (r_q.state == ST_SHDN);
    assign pg_n        = !((r_q.state == ST_RUN) && r_q.pg_done && !v_fault);

endmodule

// File: rtl/bsup_chk.sv
module bsup_chk (
    input logic clk,
    input logic rst_n,
    input logic sd_n,
    input logic vin_ok,
    input logic short_flag,
    input logic ot_flag,
    input logic conv_en,
    input logic ramp_active,
    input logic ramp_step,
    input logic dischg_en,
    input logic pg_n
);
    logic [2:0] age_q;
    logic       ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            age_q <= 3'd0;
        else if (age_q != 3'd4) age_q <= age_q + 3'd1;
    end
    assign ok = (age_q == 3'd4);

    // R1
    dischg_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dischg_en |-> (!conv_en && pg_n));

    // R1
    sd_forces_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ok && !$past(sd_n) && !$past(sd_n, 2) && !$past(sd_n, 3)) |-> dischg_en);

    // R2
    vin_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ok && $past(sd_n) && $past(sd_n, 2) && $past(sd_n, 3) &&
         !$past(vin_ok) && !$past(vin_ok, 2) && !$past(vin_ok, 3))
        |-> (!conv_en && !dischg_en && pg_n));

    // R4
    step_in_ramp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ramp_step |-> ramp_active);

    // R5
    pg_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pg_n |-> (conv_en && !ramp_active));

    // R8
    short_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ok && $past(short_flag) && $past(short_flag, 2) && $past(short_flag, 3)) |-> !conv_en);

    // R9
    hot_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ok && $past(ot_flag) && $past(ot_flag, 2) && $past(ot_flag, 3)) |-> !conv_en);

endmodule

bind buck_supervisor bsup_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .sd_n       (sd_n),
    .vin_ok     (vin_ok),
    .short_flag (short_flag),
    .ot_flag    (ot_flag),
    .conv_en    (conv_en),
    .ramp_active(ramp_active),
    .ramp_step  (ramp_step),
    .dischg_en  (dischg_en),
    .pg_n       (pg_n)
);

// File: tb/buck_supervisor_tb_top.sv
module buck_supervisor_tb_top;

    localparam int DIV   = 4;
    localparam int SSU   = 3;
    localparam int PGD   = 10;
    localparam int OCW   = 5;
    localparam int RTY   = 8;
    localparam int FILT  = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sd_n = 1'b0, vin_ok = 1'b0, por_done = 1'b0;
    logic ov_flag = 1'b0, uv_flag = 1'b0, ilim_flag = 1'b0;
    logic short_flag = 1'b0, ot_flag = 1'b0;
    logic [1:0] ss_sel = 2'd0;
    logic conv_en, ramp_active, ramp_step, dischg_en, pg_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    buck_supervisor #(
        .TICK_DIV      (DIV),
        .SS_UNIT_TICKS (SSU),
        .PG_DELAY_TICKS(PGD),
        .OC_WIN_TICKS  (OCW),
        .RETRY_TICKS   (RTY),
        .FILT_CYCLES   (FILT)
    ) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .sd_n       (sd_n),
        .vin_ok     (vin_ok),
        .por_done   (por_done),
        .ov_flag    (ov_flag),
        .uv_flag    (uv_flag),
        .ilim_flag  (ilim_flag),
        .short_flag (short_flag),
        .ot_flag    (ot_flag),
        .ss_sel     (ss_sel),
        .conv_en    (conv_en),
        .ramp_active(ramp_active),
        .ramp_step  (ramp_step),
        .dischg_en  (dischg_en),
        .pg_n       (pg_n)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_ramp_rise(input int max, output int n);
        n = 0;
        while (!ramp_active && n < max) begin @(negedge clk); n++; end
    endtask

    task automatic wait_ramp_fall(input int max, output int n, output int steps);
        n = 0; steps = 0;
        while (ramp_active && n < max) begin
            if (ramp_step) steps++;
            @(negedge clk); n++;
        end
    endtask

    task automatic wait_conv_fall(input int max, output int n);
        n = 0;
        while (conv_en && n < max) begin @(negedge clk); n++; end
    endtask

    task automatic wait_pg_low(input int max, output int n);
        n = 0;
        while (pg_n && n < max) begin @(negedge clk); n++; end
    endtask

    task automatic bring_up(input logic [1:0] code);
        int n, s;
        sd_n = 1'b0; cyc(5);
        ss_sel = code; sd_n = 1'b1;
        wait_ramp_rise(20, n);
        wait_ramp_fall(200, n, s);
        wait_pg_low(100, n);
    endtask

    task automatic t_reset;
        cyc(1);
        chk(pg_n == 1'b1, "R2", "reset pg_n", pg_n, 1);
        chk(conv_en == 1'b0, "R2", "reset conv_en", conv_en, 0);
        chk(dischg_en == 1'b0, "R2", "reset dischg_en", dischg_en, 0);
        rst_n = 1'b1;
    endtask

    task automatic t_shutdown;
        vin_ok = 1'b1; sd_n = 1'b0; cyc(5);
        chk(dischg_en == 1'b1, "R1", "shutdown dischg_en", dischg_en, 1);
        chk(conv_en == 1'b0, "R1", "shutdown conv_en", conv_en, 0);
        chk(pg_n == 1'b1, "R1", "shutdown pg_n", pg_n, 1);
    endtask

    task automatic t_por_gate;
        int n;
        bit bad = 0;
        sd_n = 1'b1;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (conv_en || ramp_active || (i > 4 && dischg_en)) bad = 1;
        end
        chk(!bad, "R3", "converter off while por low", bad, 0);
        por_done = 1'b1;
        wait_ramp_rise(10, n);
        chk(ramp_active && conv_en, "R3", "soft start after por", ramp_active, 1);
    endtask

    task automatic t_softstart_codes;
        for (int code = 0; code < 4; code++) begin
            int n, dur, steps, exp_t;
            sd_n = 1'b0; cyc(5);
            ss_sel = code[1:0]; sd_n = 1'b1;
            wait_ramp_rise(20, n);
            cyc(1);
            ss_sel = ~code[1:0];
            exp_t = SSU * (8 >> code);
            wait_ramp_fall(400, dur, steps);
            dur = dur + 1;
            chk(dur >= exp_t * DIV - 1 && dur <= exp_t * DIV + 1, "R4",
                "soft start cycles", dur, exp_t * DIV);
            chk(steps == exp_t || steps == exp_t - 1, "R4", "ramp steps", steps, exp_t);
            chk(conv_en == 1'b1, "R4", "running after ramp", conv_en, 1);
        end
    endtask

    task automatic t_pg_delay;
        int n, s, tot;
        sd_n = 1'b0; cyc(5); ss_sel = 2'd3; sd_n = 1'b1;
        wait_ramp_rise(20, n);
        wait_ramp_fall(200, n, s);
        wait_pg_low(200, n);
        chk(n >= PGD * DIV - 3 && n <= PGD * DIV + 3, "R5", "power-good delay", n, PGD * DIV);
        // restart of the delay by an under-voltage inside the window
        sd_n = 1'b0; cyc(5); sd_n = 1'b1;
        wait_ramp_rise(20, n);
        wait_ramp_fall(200, n, s);
        cyc(10);
        uv_flag = 1'b1; cyc(12); uv_flag = 1'b0;
        wait_pg_low(300, n);
        tot = n + 22;
        chk(tot >= 22 + PGD * DIV - DIV && tot <= 26 + PGD * DIV + DIV, "R5",
            "delay restarted by fault", tot, 24 + PGD * DIV);
    endtask

    task automatic t_vfilter;
        bit bad = 0;
        ov_flag = 1'b1;
        for (int i = 0; i < FILT - 2; i++) begin @(negedge clk); if (pg_n) bad = 1; end
        ov_flag = 1'b0;
        for (int i = 0; i < 6; i++) begin @(negedge clk); if (pg_n) bad = 1; end
        chk(!bad, "R6", "short over-voltage ignored", bad, 0);
        ov_flag = 1'b1; cyc(FILT + 6);
        chk(pg_n == 1'b1, "R6", "over-voltage releases pg", pg_n, 1);
        chk(conv_en == 1'b1, "R6", "converter stays on", conv_en, 1);
        ov_flag = 1'b0; cyc(5);
        chk(pg_n == 1'b0, "R6", "pg returns after clear", pg_n, 0);
        uv_flag = 1'b1; cyc(FILT + 6);
        chk(pg_n == 1'b1 && conv_en, "R6", "under-voltage releases pg", pg_n, 1);
        uv_flag = 1'b0; cyc(5);
        chk(pg_n == 1'b0, "R6", "pg returns after uv clear", pg_n, 0);
    endtask

    task automatic t_overcurrent;
        int n;
        bit bad = 0;
        ilim_flag = 1'b1;
        for (int i = 0; i < (OCW - 2) * DIV; i++) begin @(negedge clk); if (!conv_en) bad = 1; end
        ilim_flag = 1'b0;
        for (int i = 0; i < 6; i++) begin @(negedge clk); if (!conv_en) bad = 1; end
        chk(!bad, "R7", "brief current limit tolerated", bad, 0);
        wait_pg_low(100, n);
        ilim_flag = 1'b1;
        wait_conv_fall(60, n);
        chk(n >= 17 && n <= 30, "R7", "current-limit window cycles", n, 2 + OCW * DIV);
        ilim_flag = 1'b0;
        chk(pg_n == 1'b1, "R7", "pg high after trip", pg_n, 1);
        wait_ramp_rise(100, n);
        chk(n >= RTY * DIV - 2 && n <= RTY * DIV + 4, "R7", "retry timeout", n, RTY * DIV + 1);
    endtask

    task automatic t_short;
        int n, s;
        wait_ramp_fall(200, n, s);
        short_flag = 1'b1; cyc(2); short_flag = 1'b0;
        wait_conv_fall(10, n);
        chk(conv_en == 1'b0 && n <= 3, "R8", "short turns converter off", n, 3);
        chk(pg_n == 1'b1, "R8", "pg high on short", pg_n, 1);
        wait_ramp_rise(100, n);
        chk(n >= RTY * DIV - 2 && n <= RTY * DIV + 4, "R8", "short retry timeout", n, RTY * DIV + 1);
    endtask

    task automatic t_thermal;
        int n, s;
        bit bad = 0;
        wait_ramp_fall(200, n, s);
        ot_flag = 1'b1;
        wait_conv_fall(10, n);
        chk(conv_en == 1'b0 && n <= 3, "R9", "thermal turns converter off", n, 3);
        for (int i = 0; i < 3 * RTY * DIV; i++) begin
            @(negedge clk);
            if (conv_en || ramp_active) bad = 1;
        end
        chk(!bad, "R9", "held off while hot", bad, 0);
        ot_flag = 1'b0;
        wait_ramp_rise(100, n);
        chk(n >= RTY * DIV + 1 && n <= RTY * DIV + 7, "R9", "retry after cool-down", n, RTY * DIV + 4);
    endtask

    task automatic t_priority;
        int n, s;
        bit bad = 0;
        wait_ramp_fall(200, n, s);
        short_flag = 1'b1; cyc(2); short_flag = 1'b0;
        cyc(10);
        sd_n = 1'b0; vin_ok = 1'b0; cyc(4);
        chk(dischg_en == 1'b1, "R10", "shutdown wins over supply loss", dischg_en, 1);
        for (int i = 0; i < 3 * RTY * DIV; i++) begin
            @(negedge clk);
            if (conv_en || ramp_active) bad = 1;
        end
        chk(!bad, "R10", "retry aborted by shutdown", bad, 0);
        sd_n = 1'b1; cyc(5);
        chk(dischg_en == 1'b0, "R2", "power-off discharge", dischg_en, 0);
        chk(conv_en == 1'b0, "R2", "power-off converter", conv_en, 0);
        chk(pg_n == 1'b1, "R2", "power-off pg", pg_n, 1);
        vin_ok = 1'b1;
        wait_ramp_rise(20, n);
        chk(ramp_active == 1'b1, "R3", "restart after supply returns", ramp_active, 1);
    endtask

    initial begin
        cyc(3);
        t_reset;
        t_shutdown;
        t_por_gate;
        t_softstart_codes;
        t_pg_delay;
        bring_up(2'd3);
        t_vfilter;
        t_overcurrent;
        t_short;
        t_thermal;
        t_priority;
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got %0d expected %0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule